// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a small synchronous static memory with pipelined reads and delayed writes, holding 32 words of 36 bits. Every access goes through a fixed two-stage pipeline, whether it reads or writes. Because of this, a read and a write can follow each other on consecutive cycles with no dead cycle on the data buses. On each clock edge where the clock enable is high, the core samples an address, a direction bit, a load/advance control, three chip selects, four byte-write enables and a burst-order bit.

A load cycle opens a new access at the sampled address. Each following advance cycle steps the two low address bits through a four-word burst, in linear or interleaved order. The upper address bits stay at the loaded base. The direction and the order are fixed at the load. Read results leave through an output register, and a drive flag tells the surrounding logic when the data bus carries a valid read word. When the clock enable is low, the entire pipeline holds still.

Top module: `burst_sram_core`

## Requirements
- R1: A burst stays inside one aligned group of four words. The upper address bits keep the loaded base, and after four accesses the two low bits return to the base value.
- R2: With `burstIlv` low at the load cycle, the k-th access of a burst uses low bits equal to (base low bits + k) modulo 4.
- R3: With `burstIlv` high at the load cycle, the k-th access of a burst uses low bits equal to (base low bits XOR k).
- R4: `writeEn` (1 = write, 0 = read) is sampled only when `loadN` is low. During advance cycles it has no effect on the direction of the burst.
- R5: An enabled edge with `loadN` low and the core selected starts a new access at `addr` and ends any burst in progress.
- R6: The core is selected only when `selN0` = 0, `selN1` = 0 and `selP` = 1. A load while not selected performs no access, and later advance cycles perform none either, until the next selected load.
- R7: While `clkEn` is low, no state changes. This includes the array, the burst position and the output register.
- R8: The read word for an access sampled at enabled edge n is on `dataOut` after enabled edge n+2.
- R9: For a write access sampled at enabled edge n, `dataIn` and `byteWrN` are taken at enabled edge n+2. Reads and writes may alternate on every cycle.
- R10: `byteWrN[i]` = 0 writes bits 9i+8..9i of the word. `byteWrN[i]` = 1 leaves those bits unchanged.
- R11: `outDrive` is 1 only when `outEn` is 1 and the output stage holds a read result. When `outDrive` is 0, `dataOut` is zero. An output slot that follows a write or an idle access is not driven.
- R12: After reset, the core is deselected and `outDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; low freezes the core |
| addr | input | 5 | Word address sampled at a load |
| writeEn | input | 1 | Direction at a load: 1 write, 0 read |
| loadN | input | 1 | 0 loads a new access, 1 advances the burst |
| selN0 | input | 1 | Chip select, active low |
| selN1 | input | 1 | Chip select, active low |
| selP | input | 1 | Chip select, active high |
| byteWrN | input | 4 | Per-lane write enables, active low |
| burstIlv | input | 1 | Burst order at a load: 1 interleaved, 0 linear |
| dataIn | input | 36 | Write data, taken two enabled edges after the access |
| outEn | input | 1 | Output enable |
| dataOut | output | 36 | Read data, zero when not driven |
| outDrive | output | 1 | Data bus carries a valid read word |

## Verification
The case most likely to go wrong is an edge on which the array commits a delayed write while a read issued one cycle later is still in flight. The bench produces this with back-to-back alternating write and read loads, including a read of the very word whose write completes one edge earlier. A scoreboard judges each output slot against a shadow memory that applies writes in pipeline order. A second case is a clock-enable freeze in the middle of a burst while the output enable toggles. Here the drive flag must follow the output enable immediately, and the held word must come back unchanged.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic step;   // enabled edge: pipeline advances
    logic wr;     // commit a write this edge
    logic rd;     // load a read word into the output stage
  } strobeT;

  // Low address bits of the k-th beat of a burst
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEn,
  input  logic              loadN,
  input  logic              selN0,
  input  logic              selN1,
  input  logic              selP,
  input  logic              burstIlv,
  output strobeT            stb,
  output logic [ADDR_W-1:0] memAddr
);

  // Burst state
  logic              activeQ, activeD;
  logic [ADDR_W-1:0] baseQ, baseD;
  logic [1:0]        beatQ, beatD;
  logic              dirWrQ, dirWrD;
  logic              ilvQ, ilvD;
  logic              selected;
  logic [ADDR_W-1:0] accAddr;

  // Pipeline stages
  logic              s1ValidQ, s1WriteQ;
  logic [ADDR_W-1:0] s1AddrQ;
  logic              s2ValidQ, s2WriteQ;
  logic [ADDR_W-1:0] s2AddrQ;

  assign selected = !selN0 && !selN1 && selP;

  always_comb begin
    activeD = activeQ;
    baseD   = baseQ;
    beatD   = beatQ;
    dirWrD  = dirWrQ;
    ilvD    = ilvQ;
    if (!loadN) begin
      activeD = selected;
      baseD   = addr;
      beatD   = 2'd0;
      dirWrD  = writeEn;
      ilvD    = burstIlv;
    end else if (activeQ) begin
      beatD = beatQ + 2'd1;
    end
  end

  assign accAddr = {baseD[ADDR_W-1:2], burstLow(baseD[1:0], beatD, ilvD)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      baseQ    <= '0;
      beatQ    <= 2'd0;
      dirWrQ   <= 1'b0;
      ilvQ     <= 1'b1;
      s1ValidQ <= 1'b0;
      s1WriteQ <= 1'b0;
      s1AddrQ  <= '0;
      s2ValidQ <= 1'b0;
      s2WriteQ <= 1'b0;
      s2AddrQ  <= '0;
    end else if (clkEn) begin
      activeQ  <= activeD;
      baseQ    <= baseD;
      beatQ    <= beatD;
      dirWrQ   <= dirWrD;
      ilvQ     <= ilvD;
      s1ValidQ <= activeD;
      s1WriteQ <= dirWrD;
      s1AddrQ  <= accAddr;
      s2ValidQ <= s1ValidQ;
      s2WriteQ <= s1WriteQ;
      s2AddrQ  <= s1AddrQ;
    end
  end

  assign stb.step = clkEn;
  assign stb.wr   = clkEn && s2ValidQ && s2WriteQ;
  assign stb.rd   = clkEn && s2ValidQ && !s2WriteQ;
  assign memAddr  = s2AddrQ;

  AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && loadN && activeQ |=> s1AddrQ[ADDR_W-1:2] == $past(s1AddrQ[ADDR_W-1:2])); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && loadN && activeQ && !ilvQ |=> s1AddrQ[1:0] == $past(s1AddrQ[1:0]) + 2'd1); // R2
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && loadN && activeQ |=> s1WriteQ == $past(s1WriteQ)); // R4
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && !loadN && !selN0 && !selN1 && selP |=> s1ValidQ && s1AddrQ == $past(addr)); // R5
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && !loadN && (selN0 || selN1 || !selP) |=> !s1ValidQ); // R6
  AST_FREEZE_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(s1AddrQ) && $stable(s1ValidQ) && $stable(s2ValidQ) && $stable(s2AddrQ)); // R7

endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outDrive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] outDataQ;
  logic              outValidQ;

  // One storage bank per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.wr && !byteWrN[g])
        laneMem[memAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[memAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      outDataQ  <= '0;
    end else if (stb.step) begin
      outValidQ <= stb.rd;
      if (stb.rd) outDataQ <= rdWord;
    end
  end

  assign outDrive = outValidQ && outEn;
  assign dataOut  = outDrive ? outDataQ : '0;

  AST_FREEZE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.step |=> $stable(outDataQ) && $stable(outValidQ)); // R7
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |=> !outDrive); // R11

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEn,
  input  logic              loadN,
  input  logic              selN0,
  input  logic              selN1,
  input  logic              selP,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              burstIlv,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outDrive
);

  strobeT            stb;
  logic [ADDR_W-1:0] memAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .addr     (addr),
    .writeEn  (writeEn),
    .loadN    (loadN),
    .selN0    (selN0),
    .selN1    (selN1),
    .selP     (selP),
    .burstIlv (burstIlv),
    .stb      (stb),
    .memAddr  (memAddr)
  );

  burst_sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memAddr  (memAddr),
    .dataIn   (dataIn),
    .byteWrN  (byteWrN),
    .outEn    (outEn),
    .dataOut  (dataOut),
    .outDrive (outDrive)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rstN) |-> !outDrive); // R12

endmodule

// File: tb/test_burst_sram_core.sv
module test_burst_sram_core;

  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic [4:0]  addr = '0;
  logic        writeEn = 1'b0;
  logic        loadN = 1'b1;
  logic        selN0 = 1'b1;
  logic        selN1 = 1'b1;
  logic        selP = 1'b0;
  logic [3:0]  byteWrN = 4'hF;
  logic        burstIlv = 1'b1;
  logic [35:0] dataIn = '0;
  logic        outEn = 1'b1;
  logic [35:0] dataOut;
  logic        outDrive;

  always #(PER/2) clk = ~clk;

  burst_sram_core i_burst_sram_core (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .writeEn(writeEn),
    .loadN(loadN), .selN0(selN0), .selN1(selN1), .selP(selP),
    .byteWrN(byteWrN), .burstIlv(burstIlv), .dataIn(dataIn),
    .outEn(outEn), .dataOut(dataOut), .outDrive(outDrive)
  );

  typedef struct { int due; bit wr; logic [4:0] a; } opT;
  typedef struct { int edgeNo; bit drive; bit known; logic [35:0] data; } expT;

  opT  opQ[$];
  expT expQ[$];

  logic [35:0] shadow [32];
  bit          known  [32];

  int    checks = 0, errors = 0, edgeNum = 0;
  bit    monOn = 1'b0, done = 1'b0;
  string curReq = "R12";

  // bench model of the burst state
  bit       mActive = 1'b0, mWr = 1'b0, mIlv = 1'b1;
  bit [4:0] mBase = '0;
  bit [1:0] mBeat = '0;

  function automatic logic [35:0] wdata(input int m);
    return {4'(m), 32'(m) * 32'h9E3779B1};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // driver: sets inputs for one clock and pushes the expected output slot
  task automatic tick(input bit en, input bit ld, input bit wr, input logic [4:0] a,
                      input logic [2:0] sp, input bit ilv, input logic [3:0] bw);
    @(negedge clk);
    clkEn = en; loadN = ld; writeEn = wr; addr = a;
    {selP, selN1, selN0} = sp; burstIlv = ilv; byteWrN = bw;
    if (en) begin
      int m;
      expT e;
      m = edgeNum + 1;
      dataIn = wdata(m);
      e.edgeNo = m; e.drive = 0; e.known = 0; e.data = '0;
      if (opQ.size() > 0 && opQ[0].due == m) begin
        opT op;
        op = opQ.pop_front();
        if (op.wr) begin
          for (int l = 0; l < 4; l++)
            if (!bw[l]) shadow[op.a][l*9 +: 9] = dataIn[l*9 +: 9];
          if (bw == 4'h0) known[op.a] = 1'b1;
        end else begin
          e.drive = 1; e.known = known[op.a]; e.data = shadow[op.a];
        end
      end
      expQ.push_back(e);
      if (!ld) begin
        mActive = (sp == 3'b100);
        mBase = a; mBeat = 2'd0; mWr = wr; mIlv = ilv;
      end else if (mActive) begin
        mBeat = mBeat + 2'd1;
      end
      if (mActive) begin
        opT n;
        n.due = m + 2; n.wr = mWr;
        n.a = {mBase[4:2], mIlv ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat)};
        opQ.push_back(n);
      end
      edgeNum = m;
    end
  endtask

  task automatic acc(input bit ld, input bit wr, input logic [4:0] a, input bit ilv);
    tick(1, ld, wr, a, 3'b100, ilv, 4'h0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 5'h00, 3'b000, 0, 4'h0);
  endtask
  task automatic burst(input bit wr, input logic [4:0] a, input bit ilv);
    acc(0, wr, a, ilv);
    for (int i = 0; i < 3; i++) acc(1, wr, a, ilv);
  endtask

  // monitor: compares each output slot with the scoreboard
  bit          lastDrive = 0, lastKnown = 0;
  logic [35:0] lastData = '0;
  initial begin
    forever begin
      bit en, expDrive;
      @(posedge clk);
      en = clkEn;
      #(PER/4);
      if (monOn) begin
        if (en && expQ.size() > 0) begin
          expT e;
          e = expQ.pop_front();
          lastDrive = e.drive; lastKnown = e.known; lastData = e.data;
        end
        expDrive = lastDrive && outEn;
        chk(outDrive == expDrive, "outDrive", 36'(outDrive), 36'(expDrive));
        if (!expDrive)
          chk(dataOut == '0, "undriven dataOut", dataOut, '0);
        else if (lastKnown)
          chk(dataOut == lastData, "read data", dataOut, lastData);
      end
    end
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin shadow[i] = '0; known[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R12";
    chk(outDrive == 1'b0, "reset outDrive", 36'(outDrive), 36'd0);
    chk(dataOut == '0, "reset dataOut", dataOut, '0);
    monOn = 1'b1;
    // R12: advances straight after reset perform no access
    acc(1, 1, 5'h03, 0); acc(1, 0, 5'h03, 0); idle(2);

    curReq = "R2";  // linear write 6,7,4,5 then linear read 4..7
    burst(1, 5'h06, 0); idle(2);
    burst(0, 5'h04, 0); idle(3);

    curReq = "R3";  // interleaved write B,A,9,8 then interleaved read 9,8,B,A
    burst(1, 5'h0B, 1); idle(2);
    burst(0, 5'h09, 1); idle(3);

    curReq = "R1";  // R1: burst continues past four beats and wraps in its group
    acc(0, 0, 5'h07, 0);
    for (int i = 0; i < 5; i++) acc(1, 0, 5'h00, 0);
    idle(3);

    curReq = "R9";  // alternating writes and reads without idle
    acc(0, 1, 5'h10, 0); acc(0, 0, 5'h04, 0); acc(0, 1, 5'h11, 0);
    acc(0, 0, 5'h10, 0); acc(0, 1, 5'h12, 0); acc(0, 0, 5'h11, 0);
    acc(0, 0, 5'h12, 0); idle(3);

    curReq = "R4";  // writeEn high during advances of a read burst is ignored
    acc(0, 0, 5'h08, 0);
    for (int i = 0; i < 3; i++) acc(1, 1, 5'h00, 0);
    idle(2); burst(0, 5'h08, 0); idle(3);

    curReq = "R10"; // lanes 0 and 2 written, lanes 1 and 3 kept
    acc(0, 1, 5'h10, 0); idle(1);
    tick(1, 0, 0, 5'h00, 3'b000, 0, 4'b1010);
    idle(2); acc(0, 0, 5'h10, 0); idle(3);

    curReq = "R6";  // each wrong select pattern blocks a write burst
    tick(1, 0, 1, 5'h04, 3'b101, 0, 4'h0); tick(1, 1, 1, 5'h00, 3'b100, 0, 4'h0);
    tick(1, 0, 1, 5'h05, 3'b110, 0, 4'h0); tick(1, 1, 1, 5'h00, 3'b100, 0, 4'h0);
    tick(1, 0, 1, 5'h06, 3'b000, 0, 4'h0); tick(1, 1, 1, 5'h00, 3'b100, 0, 4'h0);
    idle(2); burst(0, 5'h04, 0); idle(3);

    curReq = "R5";  // a load cuts a burst short
    acc(0, 0, 5'h08, 0); acc(1, 0, 5'h00, 0);
    acc(0, 0, 5'h10, 0); acc(1, 0, 5'h00, 0); idle(3);

    curReq = "R7";  // freeze mid-burst with output enable toggling
    acc(0, 0, 5'h08, 1); acc(1, 0, 5'h00, 1); acc(1, 0, 5'h00, 1);
    tick(0, 1, 1, 5'h1F, 3'b100, 0, 4'h0);
    outEn = 1'b0;
    tick(0, 0, 1, 5'h1F, 3'b100, 0, 4'h0);
    outEn = 1'b1;
    tick(0, 0, 1, 5'h1F, 3'b100, 0, 4'h0);
    acc(1, 0, 5'h00, 1); idle(3);

    curReq = "R8";  // single reads of several addresses
    acc(0, 0, 5'h05, 0); idle(1); acc(0, 0, 5'h0A, 0); acc(0, 0, 5'h12, 0); idle(3);

    curReq = "R11"; // output enable low hides a read burst
    acc(0, 0, 5'h08, 0); acc(1, 0, 5'h00, 0); acc(1, 0, 5'h00, 0);
    outEn = 1'b0;
    acc(1, 0, 5'h00, 0); idle(1);
    outEn = 1'b1;
    idle(4);

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule